// File: doc/BRIEF.md
# Command-Queue Interrupt Status and Enable Block

This block collects one-cycle event pulses from a command-queuing engine and reduces them to a single level-sensitive interrupt line. Each event source has one bit in each of three software-visible registers. The latch-enable register decides which events are captured. The status register holds the captured events until software clears them. The pin-enable register decides which captured events drive the interrupt line.

Clearing follows a write-zero convention. A 0 written to a status bit clears that bit, and a 1 leaves the bit as it was. Software can therefore acknowledge one source by writing a word with that one bit at 0 and all other bits at 1. The registers are reached through a plain port with an address, write data, a write strobe and registered read data. Coalescing, the bus protocol layer and the creation of the events are handled by other blocks.

Top module: `cq_irq_agg`

## Requirements
- R1: While and after a synchronous active-high reset, all three registers read zero and `irq_o` is 0.
- R2: Register byte offsets: 0x0 is status, 0x4 is latch enable and 0x8 is pin enable. Every other address reads zero, and a write to it changes nothing.
- R3: A pulse on `evt_i[n]` while latch-enable bit n is 1 sets status bit n. The bit is set at the next clock edge.
- R4: A pulse on `evt_i[n]` while latch-enable bit n is 0 leaves status bit n unchanged.
- R5: Writing 0 to a status bit clears it, and writing 1 to a status bit leaves it unchanged.
- R6: When an enabled event and a write of 0 reach the same status bit in the same cycle, the bit ends at 1.
- R7: Clearing a latch-enable bit does not clear a status bit that is already set.
- R8: Latch enable and pin enable are plain read/write registers. An event in the cycle of a latch-enable write is judged against the value held before that write.
- R9: `irq_o` is a register that carries the OR over all bits of (status AND pin enable). It takes each new value one cycle after the status and pin-enable registers take theirs.
- R10: `reg_rdata` is loaded at every edge with the register selected by `reg_addr`, using its value before that edge. Reading has no side effects.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| evt_i | input | NUM_SRC (32) | One-cycle event pulses, one per source |
| reg_addr | input | ADDR_W (4) | Byte address of the register |
| reg_wdata | input | DATA_W (32) | Write data |
| reg_wr | input | 1 | Write strobe, one cycle per write |
| reg_rdata | output | DATA_W (32) | Registered read data |
| irq_o | output | 1 | Level interrupt output, registered |

## Verification
The bench uses the default parameters: 32 sources, 32-bit data and a 4-bit address. With these values the top source bit and the full address space, including unmapped offsets, are within reach. Directed steps cover the race between an event and a clear, writes of ones to status, a latch-enable write that coincides with an event, and the use of bit 31. A seeded random phase then mixes events, writes to any address and reads, and compares the interrupt output and the read data with a reference model every cycle.

// File: rtl/cq_irq_pkg.sv
package cq_irq_pkg;
  localparam int OFF_STATUS = 0;
  localparam int OFF_LATCH  = 4;
  localparam int OFF_PIN    = 8;

  typedef enum logic [1:0] {
    SEL_NONE   = 2'd0,
    SEL_STATUS = 2'd1,
    SEL_LATCH  = 2'd2,
    SEL_PIN    = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/cq_irq_cfg_reg.sv
module cq_irq_cfg_reg #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         we,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst)     q <= '0;
    else if (we) q <= d;
  end
endmodule

// File: rtl/cq_irq_status.sv
module cq_irq_status #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] evt,
  input  logic [W-1:0] latch_en,
  input  logic [W-1:0] clr,
  output logic [W-1:0] q
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    always_ff @(posedge clk) begin
      if (rst)                        q[i] <= 1'b0;
      else if (evt[i] && latch_en[i]) q[i] <= 1'b1;
      else if (clr[i])                q[i] <= 1'b0;
    end
  end
endmodule

// File: rtl/cq_irq_rdmux.sv
module cq_irq_rdmux
  import cq_irq_pkg::*;
#(
  parameter int W      = 32,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  reg_sel_e          sel,
  input  logic [W-1:0]      status,
  input  logic [W-1:0]      latch_en,
  input  logic [W-1:0]      pin_en,
  output logic [DATA_W-1:0] rdata
);
  logic [W-1:0]      pick;
  logic [DATA_W-1:0] pick_ext;

  always_comb begin
    unique case (sel)
      SEL_STATUS: pick = status;
      SEL_LATCH:  pick = latch_en;
      SEL_PIN:    pick = pin_en;
      default:    pick = '0;
    endcase
  end

  if (W < DATA_W) begin : g_pad
    assign pick_ext = {{(DATA_W-W){1'b0}}, pick};
  end else begin : g_full
    assign pick_ext = pick;
  end

  always_ff @(posedge clk) begin
    if (rst) rdata <= '0;
    else     rdata <= pick_ext;
  end
endmodule

// File: rtl/cq_irq_agg.sv
module cq_irq_agg
  import cq_irq_pkg::*;
#(
  parameter int NUM_SRC = 32,
  parameter int DATA_W  = 32,
  parameter int ADDR_W  = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_SRC-1:0] evt_i,
  input  logic [ADDR_W-1:0]  reg_addr,
  input  logic [DATA_W-1:0]  reg_wdata,
  input  logic               reg_wr,
  output logic [DATA_W-1:0]  reg_rdata,
  output logic               irq_o
);
  reg_sel_e           sel;
  logic               wr_stat;
  logic               wr_latch;
  logic               wr_pin;
  logic [NUM_SRC-1:0] wbits;
  logic [NUM_SRC-1:0] clr_mask;
  logic [NUM_SRC-1:0] status_q;
  logic [NUM_SRC-1:0] len_q;
  logic [NUM_SRC-1:0] pen_q;

  always_comb begin
    if      (reg_addr == ADDR_W'(OFF_STATUS)) sel = SEL_STATUS;
    else if (reg_addr == ADDR_W'(OFF_LATCH))  sel = SEL_LATCH;
    else if (reg_addr == ADDR_W'(OFF_PIN))    sel = SEL_PIN;
    else                                      sel = SEL_NONE;
  end

  assign wr_stat  = reg_wr && (sel == SEL_STATUS);
  assign wr_latch = reg_wr && (sel == SEL_LATCH);
  assign wr_pin   = reg_wr && (sel == SEL_PIN);
  assign wbits    = reg_wdata[NUM_SRC-1:0];
  assign clr_mask = wr_stat ? ~wbits : '0;

  cq_irq_cfg_reg #(.W(NUM_SRC)) u_latch (
    .clk(clk), .rst(rst), .we(wr_latch), .d(wbits), .q(len_q)
  );

  cq_irq_cfg_reg #(.W(NUM_SRC)) u_pin (
    .clk(clk), .rst(rst), .we(wr_pin), .d(wbits), .q(pen_q)
  );

  cq_irq_status #(.W(NUM_SRC)) u_status (
    .clk(clk), .rst(rst), .evt(evt_i), .latch_en(len_q),
    .clr(clr_mask), .q(status_q)
  );

  cq_irq_rdmux #(.W(NUM_SRC), .DATA_W(DATA_W)) u_rd (
    .clk(clk), .rst(rst), .sel(sel), .status(status_q),
    .latch_en(len_q), .pin_en(pen_q), .rdata(reg_rdata)
  );

  always_ff @(posedge clk) begin
    if (rst) irq_o <= 1'b0;
    else     irq_o <= |(status_q & pen_q);
  end
endmodule

// File: rtl/cq_irq_chk.sv
module cq_irq_chk #(
  parameter int NUM_SRC = 32
) (
  input logic               clk,
  input logic               rst,
  input logic [NUM_SRC-1:0] evt_i,
  input logic [NUM_SRC-1:0] status_q,
  input logic [NUM_SRC-1:0] len_q,
  input logic [NUM_SRC-1:0] pen_q,
  input logic [NUM_SRC-1:0] wbits,
  input logic               wr_stat,
  input logic               irq_o
);
  // R1
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> (status_q == '0 && len_q == '0 && pen_q == '0 && !irq_o));

  // R3
  status_latch_chk: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((status_q & $past(evt_i & len_q)) == $past(evt_i & len_q)));

  // R4
  no_spurious_set_chk: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((status_q & ~$past(status_q) & ~$past(evt_i & len_q)) == '0));

  // R5
  write_one_keeps_chk: assert property (@(posedge clk) disable iff (rst)
    wr_stat |=> ((status_q & $past(status_q & wbits)) == $past(status_q & wbits)));

  // R9
  irq_follow_chk: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (irq_o == $past(|(status_q & pen_q))));
endmodule

bind cq_irq_agg cq_irq_chk #(.NUM_SRC(NUM_SRC)) u_chk (
  .clk(clk), .rst(rst), .evt_i(evt_i), .status_q(status_q), .len_q(len_q),
  .pen_q(pen_q), .wbits(wbits), .wr_stat(wr_stat), .irq_o(irq_o)
);

// File: tb/test_cq_irq_agg.sv
module test_cq_irq_agg;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] evt_i = '0;
  logic [3:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic        reg_wr = 1'b0;
  logic [31:0] reg_rdata;
  logic        irq_o;

  int total = 0;
  int bad = 0;
  logic [31:0] m_st = '0, m_len = '0, m_pen = '0, m_rd = '0;
  logic        m_irq = 1'b0;

  always #10 clk = ~clk;

  cq_irq_agg i_cq_irq_agg (
    .clk(clk), .rst(rst), .evt_i(evt_i), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_wr(reg_wr), .reg_rdata(reg_rdata), .irq_o(irq_o)
  );

  task automatic check(input logic ok, input string tag,
                       input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%h exp=%h t=%0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [31:0] sel_model(input logic [3:0] a);
    case (a)
      4'h0:    return m_st;
      4'h4:    return m_len;
      4'h8:    return m_pen;
      default: return 32'h0;
    endcase
  endfunction

  // Called at a falling edge; drives inputs, updates model at the rising edge,
  // compares at the next falling edge.
  task automatic step(input logic [31:0] e, input logic w,
                      input logic [3:0] a, input logic [31:0] d);
    logic [31:0] nst;
    evt_i = e; reg_wr = w; reg_addr = a; reg_wdata = d;
    @(posedge clk);
    m_irq = |(m_st & m_pen);
    m_rd  = sel_model(a);
    nst   = (m_st & ~((w && a == 4'h0) ? ~d : 32'h0)) | (e & m_len);
    if (w && a == 4'h4) m_len = d;
    if (w && a == 4'h8) m_pen = d;
    m_st = nst;
    @(negedge clk);
    check(irq_o === m_irq, "R9 irq", {31'b0, irq_o}, {31'b0, m_irq});
    check(reg_rdata === m_rd, "R10 rdata", reg_rdata, m_rd);
  endtask

  task automatic rd_expect(input logic [3:0] a, input logic [31:0] exp, input string tag);
    step(32'h0, 1'b0, a, 32'h0);
    check(reg_rdata === exp, tag, reg_rdata, exp);
  endtask

  initial begin
    #2_000_000;
    bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    check(irq_o === 1'b0, "R1 irq in reset", {31'b0, irq_o}, 32'h0);
    check(reg_rdata === 32'h0, "R1 rdata in reset", reg_rdata, 32'h0);
    rst = 1'b0;
    rd_expect(4'h0, 32'h0, "R1 status after reset");
    rd_expect(4'h4, 32'h0, "R1 latch after reset");
    rd_expect(4'h8, 32'h0, "R1 pin after reset");

    step(32'h0, 1'b1, 4'h4, 32'h0000_00F0);
    step(32'h0, 1'b1, 4'h8, 32'h8000_0010);
    rd_expect(4'h4, 32'h0000_00F0, "R8 latch readback");
    rd_expect(4'h8, 32'h8000_0010, "R8 pin readback");
    step(32'h0, 1'b1, 4'hC, 32'hFFFF_FFFF);
    rd_expect(4'hC, 32'h0, "R2 unmapped reads zero");
    rd_expect(4'h4, 32'h0000_00F0, "R2 unmapped write ignored");

    step(32'h0000_0001, 1'b0, 4'h0, 32'h0);
    rd_expect(4'h0, 32'h0, "R4 disabled event ignored");
    step(32'h0000_0010, 1'b0, 4'h0, 32'h0);
    rd_expect(4'h0, 32'h0000_0010, "R3 enabled event latched");
    check(irq_o === 1'b1, "R9 irq high", {31'b0, irq_o}, 32'h1);

    step(32'h0, 1'b1, 4'h0, 32'hFFFF_FFFF);
    rd_expect(4'h0, 32'h0000_0010, "R5 write one keeps");
    step(32'h0, 1'b1, 4'h0, 32'hFFFF_FFEF);
    rd_expect(4'h0, 32'h0, "R5 write zero clears");
    step(32'h0, 1'b0, 4'h0, 32'h0);
    check(irq_o === 1'b0, "R9 irq low", {31'b0, irq_o}, 32'h0);

    step(32'h0000_0020, 1'b1, 4'h0, 32'h0);
    rd_expect(4'h0, 32'h0000_0020, "R6 event wins over clear");

    step(32'h0, 1'b1, 4'h4, 32'h0);
    rd_expect(4'h0, 32'h0000_0020, "R7 latch disable keeps status");

    step(32'h0000_0040, 1'b1, 4'h4, 32'h0000_0040);
    rd_expect(4'h0, 32'h0000_0020, "R8 old enable used in write cycle");
    step(32'h0000_0040, 1'b0, 4'h0, 32'h0);
    rd_expect(4'h0, 32'h0000_0060, "R8 new enable next cycle");

    step(32'h0, 1'b1, 4'h4, 32'h8000_0000);
    step(32'h0, 1'b1, 4'h0, 32'h0);
    step(32'h0, 1'b0, 4'h0, 32'h0);
    check(irq_o === 1'b0, "R9 irq low before bit31", {31'b0, irq_o}, 32'h0);
    step(32'h8000_0000, 1'b0, 4'h0, 32'h0);
    rd_expect(4'h0, 32'h8000_0000, "R3 bit31 latched");
    check(irq_o === 1'b1, "R9 irq from bit31", {31'b0, irq_o}, 32'h1);
    rd_expect(4'h0, 32'h8000_0000, "R10 read has no side effect");

    for (int i = 0; i < 3000; i++) begin
      logic [31:0] e, d;
      logic [3:0]  a;
      logic        w;
      e = $urandom() & $urandom() & $urandom();
      w = ($urandom_range(0, 3) == 0);
      case ($urandom_range(0, 4))
        0: a = 4'h0;
        1: a = 4'h4;
        2: a = 4'h8;
        3: a = 4'hC;
        default: a = 4'($urandom_range(0, 15));
      endcase
      d = $urandom() | $urandom();
      step(e, w, a, d);
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule